// File: doc/BRIEF.md
# Acknowledgment Turnaround Timer

This block sits behind a radio receiver and decides whether an acknowledgment frame must go out after a received frame, and at what moment. The receiver reports that a frame has been received and passed filtering with a one-cycle completion pulse. In the same cycle it presents the frame's acknowledgment-request bit. The block then waits a number of symbol periods and issues a one-cycle start strobe to the transmit path. A symbol period is 16 µs, and its boundaries arrive on a one-cycle tick input.

Two configuration bits choose the wait. The reduced-timing bit selects a short turnaround of 2 symbols (32 µs). Without it, slotted operation uses the earliest permitted point of 6 symbols. Otherwise the wait is the standard 12 symbols. The configuration is captured together with the completion pulse. While a wait is pending, a busy flag is high and further completion pulses are ignored.

Top module: `ack_turnaround_ctl`

## Requirements
- R1: A synchronous active-high reset drops `ack_busy` and `ack_tx_start`, and discards any pending acknowledgment so that no strobe follows from it.
- R2: A completion pulse with `ack_requested` low starts nothing: `ack_busy` stays low and no strobe follows.
- R3: With `fast_ack` = 0 and `slotted` = 0, the strobe follows the 12th symbol tick after the accepted completion pulse.
- R4: With `fast_ack` = 1, the strobe follows the 2nd symbol tick after the accepted completion pulse.
- R5: With `fast_ack` = 0 and `slotted` = 1, the strobe follows the 6th symbol tick after the accepted completion pulse.
- R6: When `fast_ack` and `slotted` are both 1, the reduced delay of R4 applies.
- R7: `ack_tx_start` is high for exactly one cycle. It is high in the cycle after the clock edge that sampled the final tick, and `ack_busy` falls in that same cycle.
- R8: A completion pulse that arrives while `ack_busy` is high is ignored. It does not restart the delay and does not add a strobe.
- R9: `fast_ack` and `slotted` are sampled only with the accepted completion pulse. Changing them during a wait leaves the wait unchanged.
- R10: `ack_busy` goes high in the cycle after an accepted completion pulse. A tick in the same cycle as that pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle pulse: a frame was received and accepted |
| ack_requested | input | 1 | Acknowledgment-request bit of that frame, valid with `rx_done` |
| fast_ack | input | 1 | Reduced turnaround select (2 symbols) |
| slotted | input | 1 | Slotted operation select (6 symbols earliest) |
| sym_tick | input | 1 | One-cycle pulse at each symbol-period boundary |
| ack_tx_start | output | 1 | One-cycle strobe that starts acknowledgment transmission |
| ack_busy | output | 1 | High while an acknowledgment wait is pending |

## Verification
The bench builds the block with its default delays of 12, 6 and 2 symbols, so that each of the three turnaround choices is exercised at its real length. Ticks are driven with gaps of one and three clock cycles. With a gap of one, the final tick and the strobe fall on neighbouring edges. Larger gaps separate tick counting from clock counting. The bench injects completion pulses, configuration flips and a reset at chosen tick indices in the middle of a wait, which makes R1, R8 and R9 reachable within a few dozen cycles.

// File: rtl/ack_turnaround_pkg.sv
package ack_turnaround_pkg;

    typedef enum logic [1:0] {
        ACK_STD  = 2'd0,
        ACK_SLOT = 2'd1,
        ACK_FAST = 2'd2
    } ack_mode_e;

    typedef struct packed {
        logic fast;
        logic slotted;
    } ack_cfg_t;

    // Reduced timing wins over slotted, which wins over standard.
    function automatic ack_mode_e pick_mode(input ack_cfg_t c);
        if (c.fast)
            return ACK_FAST;
        else if (c.slotted)
            return ACK_SLOT;
        return ACK_STD;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ack_delay_sel.sv
module ack_delay_sel
    import ack_turnaround_pkg::*;
#(
    parameter int STD_SYMS  = 12,
    parameter int SLOT_SYMS = 6,
    parameter int FAST_SYMS = 2,
    parameter int CNT_W     = 4
) (
    input  ack_cfg_t         cfg,
    output logic [CNT_W-1:0] delay
);
    ack_mode_e mode;

    always_comb begin
        mode = pick_mode(cfg);
        unique case (mode)
            ACK_FAST: delay = CNT_W'(FAST_SYMS);
            ACK_SLOT: delay = CNT_W'(SLOT_SYMS);
            default:  delay = CNT_W'(STD_SYMS);
        endcase
    end
endmodule

// File: rtl/ack_countdown.sv
module ack_countdown #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             active,
    output logic             fire
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            active <= 1'b0;
            fire   <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!active) begin
                if (load) begin
                    remain <= load_val;
                    active <= 1'b1;
                end
            end else if (tick) begin
                if (remain == CNT_W'(1)) begin
                    remain <= '0;
                    active <= 1'b0;
                    fire   <= 1'b1;
                end else begin
                    remain <= remain - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ack_turnaround_ctl.sv
module ack_turnaround_ctl
    import ack_turnaround_pkg::*;
#(
    parameter int STD_SYMS  = 12,
    parameter int SLOT_SYMS = 6,
    parameter int FAST_SYMS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_done,
    input  logic ack_requested,
    input  logic fast_ack,
    input  logic slotted,
    input  logic sym_tick,
    output logic ack_tx_start,
    output logic ack_busy
);
    localparam int MAX_SYMS = max3(STD_SYMS, SLOT_SYMS, FAST_SYMS);
    localparam int CNT_W    = $clog2(MAX_SYMS + 1);

    ack_cfg_t         cfg_now;
    logic [CNT_W-1:0] delay_now;
    logic             accept;

    assign cfg_now = '{fast: fast_ack, slotted: slotted};
    // A new request is taken only when no wait is pending (R8).
    assign accept  = rx_done && ack_requested && !ack_busy;

    ack_delay_sel #(
        .STD_SYMS (STD_SYMS),
        .SLOT_SYMS(SLOT_SYMS),
        .FAST_SYMS(FAST_SYMS),
        .CNT_W    (CNT_W)
    ) u_sel (
        .cfg  (cfg_now),
        .delay(delay_now)
    );

    ack_countdown #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_val(delay_now),
        .tick    (sym_tick),
        .active  (ack_busy),
        .fire    (ack_tx_start)
    );
endmodule

// File: rtl/ack_turnaround_chk.sv
module ack_turnaround_chk #(
    parameter int STD_SYMS  = 12,
    parameter int SLOT_SYMS = 6,
    parameter int FAST_SYMS = 2
) (
    input logic clk,
    input logic rst,
    input logic rx_done,
    input logic ack_requested,
    input logic fast_ack,
    input logic slotted,
    input logic sym_tick,
    input logic ack_tx_start,
    input logic ack_busy
);
    int exp_d;
    int seen;

    initial begin
        assert (STD_SYMS >= 1 && SLOT_SYMS >= 1 && FAST_SYMS >= 1)
            else $error("delays must be at least one symbol");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_d <= 0;
            seen  <= 0;
        end else if (rx_done && ack_requested && !ack_busy) begin
            exp_d <= fast_ack ? FAST_SYMS : (slotted ? SLOT_SYMS : STD_SYMS);
            seen  <= 0;
        end else if (ack_busy && sym_tick) begin
            seen <= seen + 1;
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!ack_busy && !ack_tx_start));

    p_start_needs_request_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_busy) |-> $past(rx_done && ack_requested));

    // Tick count at the strobe matches the delay chosen at acceptance (R3 R4 R5 R6 R8 R9).
    p_delay_match_r3: assert property (@(posedge clk) disable iff (rst)
        ack_tx_start |-> (seen == exp_d));

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        ack_tx_start |=> !ack_tx_start);

    p_strobe_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        ack_tx_start |-> $past(ack_busy));

    p_busy_ends_with_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_busy) && $past(!rst)) |-> ack_tx_start);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_done && ack_requested && !ack_busy) |=> ack_busy);
endmodule

bind ack_turnaround_ctl ack_turnaround_chk #(
    .STD_SYMS (STD_SYMS),
    .SLOT_SYMS(SLOT_SYMS),
    .FAST_SYMS(FAST_SYMS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_done      (rx_done),
    .ack_requested(ack_requested),
    .fast_ack     (fast_ack),
    .slotted      (slotted),
    .sym_tick     (sym_tick),
    .ack_tx_start (ack_tx_start),
    .ack_busy     (ack_busy)
);

// File: tb/sim_ack_turnaround_ctl.sv
module sim_ack_turnaround_ctl;
    localparam int STD  = 12;
    localparam int SLOT = 6;
    localparam int FAST = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_done = 1'b0, ack_requested = 1'b0, fast_ack = 1'b0, slotted = 1'b0, sym_tick = 1'b0;
    logic ack_tx_start, ack_busy;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    ack_turnaround_ctl #(.STD_SYMS(STD), .SLOT_SYMS(SLOT), .FAST_SYMS(FAST)) u0 (
        .clk(clk), .rst(rst), .rx_done(rx_done), .ack_requested(ack_requested),
        .fast_ack(fast_ack), .slotted(slotted), .sym_tick(sym_tick),
        .ack_tx_start(ack_tx_start), .ack_busy(ack_busy)
    );

    task automatic check(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops the expected strobe cycle and compares (R3..R9).
    logic prev_strobe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_strobe && ack_tx_start) begin
                compared++; mismatched++;
                $display("FAIL R7: strobe wider than one cycle, actual 1 expected 0 at cycle %0d", cyc);
            end
            if (exp_q.size() > 0 && cyc > exp_q[0] && !ack_tx_start) begin
                compared++; mismatched++;
                $display("FAIL R3-strobe-missing: actual none expected cycle %0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (ack_tx_start) begin
                compared++;
                if (exp_q.size() == 0) begin
                    mismatched++;
                    $display("FAIL R2: unexpected strobe at cycle %0d, expected none", cyc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        mismatched++;
                        $display("FAIL R7: strobe at cycle %0d expected %0d", cyc, e);
                    end
                end
                compared++;
                if (ack_busy !== 1'b0) begin
                    mismatched++;
                    $display("FAIL R7: busy with strobe actual %b expected 0", ack_busy);
                end
            end
        end
        prev_strobe = ack_tx_start;
    end

    // Driver: one frame; optional re-pulse (R8), config flip (R9), reset (R1) at tick index k.
    task automatic frame(input logic req, input logic fa, input logic sl, input int gap,
                         input int again_at, input int flip_at, input int rst_at,
                         input logic tick_with_rx);
        int n;
        @(negedge clk);
        rx_done = 1; ack_requested = req; fast_ack = fa; slotted = sl;
        sym_tick = tick_with_rx;
        n = fa ? FAST : (sl ? SLOT : STD);
        if (req) exp_q.push_back(cyc + 1 + gap * n);
        @(negedge clk);
        rx_done = 0; sym_tick = 0;
        check(req ? "R10" : "R2", ack_busy, req);
        for (int k = 1; k <= n * gap; k++) begin
            sym_tick = ((k % gap) == 0);
            rx_done  = (k == again_at);
            if (k == again_at) begin
                ack_requested = 1; fast_ack = 1; slotted = 1;
            end
            if (k == flip_at) begin
                fast_ack = ~fast_ack; slotted = ~slotted;
            end
            rst = (k == rst_at);
            if (k == rst_at && exp_q.size() > 0) void'(exp_q.pop_back());
            @(negedge clk);
            rst = 0;
            if (k == rst_at) begin
                check("R1", ack_busy, 1'b0);
                check("R1", ack_tx_start, 1'b0);
            end
        end
        rx_done = 0; sym_tick = 0;
        check("R7", ack_busy, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ack_busy, 1'b0);
        check("R1", ack_tx_start, 1'b0);
        rst = 0;
        frame(1, 0, 0, 1, 0, 0, 0, 0);   // R3 standard
        frame(1, 1, 0, 1, 0, 0, 0, 0);   // R4 reduced
        frame(1, 0, 1, 1, 0, 0, 0, 0);   // R5 slotted
        frame(1, 1, 1, 3, 0, 0, 0, 0);   // R6 reduced over slotted
        frame(1, 0, 0, 3, 0, 0, 0, 1);   // R10 tick with rx not counted
        frame(0, 0, 0, 1, 0, 0, 0, 0);   // R2 no request
        frame(0, 1, 0, 3, 0, 0, 0, 0);   // R2 no request, reduced
        frame(1, 0, 0, 1, 4, 0, 0, 0);   // R8 re-pulse ignored
        frame(1, 0, 1, 3, 7, 0, 0, 0);   // R8 slotted, gap 3
        frame(1, 0, 0, 1, 0, 3, 0, 0);   // R9 config flip mid-wait
        frame(1, 1, 0, 3, 0, 2, 0, 0);   // R9 reduced then flip
        frame(1, 0, 0, 1, 0, 0, 5, 0);   // R1 reset mid-wait
        repeat (20) begin
            sym_tick = 1; @(negedge clk);
        end
        sym_tick = 0;
        check("R1", ack_busy, 1'b0);
        frame(1, 0, 1, 1, 0, 0, 0, 0);   // R5 after reset
        repeat (5) @(negedge clk);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R3: %0d strobes outstanding, expected 0", exp_q.size());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                compared++; mismatched++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule